// File: doc/BRIEF.md
# Packed Unpack-High Interleave Unit

This execution unit carries out the packed-integer "unpack high" operation. It takes the upper half of a destination operand and the upper half of a source operand and interleaves their elements into one result. Each destination element lands in the lower slot of a pair, and the matching source element lands in the slot just above it. The element width can be 8, 16, 32 or 64 bits. The operand width is 64 or 128 bits. Both come from the opcode byte and a flag that marks the operand-size prefix.

An issue stage presents the opcode byte, the prefix flag and both 128-bit operands with a valid/ready handshake. One cycle after it is accepted, a registered result comes out with a valid strobe and a two-bit write mask for the register file. An opcode the unit does not recognise, or the quadword opcode without the prefix, produces a one-cycle illegal-operation pulse and no result. The unit has no flag outputs, so it cannot change any arithmetic flags. Fetch, address generation, memory access and writeback are done elsewhere.

Top module: `unpack_hi_unit`

## Requirements
- R1: The opcode byte selects the element width: 0x68 gives 8 bits, 0x69 gives 16 bits, 0x6A gives 32 bits and 0x6D gives 64 bits.
- R2: With `in_wide`=1 the operation works on 128-bit operands and reads only bits [127:64] of each operand. With `in_wide`=0 it works on 64-bit operands and reads only bits [63:32]. Changing the unused low bits does not change the result.
- R3: Result element 2k equals the k-th element of the destination's upper half. Result element 2k+1 equals the k-th element of the source's upper half.
- R4: For opcode 0x6D with `in_wide`=1, result[63:0] equals dst[127:64] and result[127:64] equals src[127:64].
- R5: When the source is all zeros, the result holds each upper-half destination element zero-extended to twice its width.
- R6: In the 64-bit form, result[127:64] is zero and `out_wmask` is 2'b01. In the 128-bit form, `out_wmask` is 2'b11.
- R7: Opcode 0x6D with `in_wide`=0, or any opcode other than the four in R1, gives `out_illegal`=1 for the single cycle after the handshake. In that cycle `out_valid` stays 0.
- R8: A legal operation accepted while `in_valid` and `in_ready` are both high appears with `out_valid`=1 one clock later.
- R9: While `out_valid`=1 and `out_ready`=0, `in_ready` is 0 and `out_result` and `out_wmask` hold steady. The unit takes no new operation during that time.
- R10: A synchronous active-high reset clears `out_valid` and `out_illegal`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Operation offered |
| in_ready | output | 1 | Unit can accept an operation |
| in_opcode | input | 8 | Opcode byte that follows the escape byte |
| in_wide | input | 1 | Operand-size prefix present (128-bit form) |
| in_dst | input | 128 | Destination operand |
| in_src | input | 128 | Source operand |
| out_valid | output | 1 | Result valid |
| out_ready | input | 1 | Consumer takes the result |
| out_result | output | 128 | Interleaved result |
| out_wmask | output | 2 | Write enable per 64-bit half, bit 0 for the low half |
| out_illegal | output | 1 | Pulse for an unsupported opcode/width pair |

## Verification
The hardest case to reach from the ports is a new operation that waits while a result is stalled and is then accepted in the same cycle that the old result drains. The bench parks a result with `out_ready` low, offers a second operation with different data, and checks that the held result does not change and that `in_ready` stays low. It then raises `out_ready` and checks that exactly the second operation's result follows. Random opcodes, including invalid bytes and 0x6D without the prefix, are mixed with directed zero-source and low-half-disturbance cases.

// File: rtl/unpkh_pkg.sv
package unpkh_pkg;
  localparam int DATA_W  = 128;
  localparam int LANE_W  = 64;
  localparam int N_LANES = DATA_W / LANE_W;
  localparam int N_SIZES = 4;

  localparam logic [7:0] OPC_BYTE  = 8'h68;
  localparam logic [7:0] OPC_WORD  = 8'h69;
  localparam logic [7:0] OPC_DWORD = 8'h6A;
  localparam logic [7:0] OPC_QWORD = 8'h6D;

  typedef enum logic [1:0] {
    EL_8  = 2'd0,
    EL_16 = 2'd1,
    EL_32 = 2'd2,
    EL_64 = 2'd3
  } elsz_t;

  typedef struct packed {
    logic  legal;
    logic  wide;
    elsz_t sz;
  } dec_t;
endpackage

// File: rtl/unpkh_decode.sv
module unpkh_decode
  import unpkh_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  logic [7:0] opcode,
  input  logic       wide,
  output dec_t       dec
);
  always_comb begin
    dec.wide  = wide;
    dec.legal = 1'b1;
    dec.sz    = EL_8;
    unique case (opcode)
      OPC_BYTE:  dec.sz = EL_8;
      OPC_WORD:  dec.sz = EL_16;
      OPC_DWORD: dec.sz = EL_32;
      OPC_QWORD: begin
        dec.sz    = EL_64;
        dec.legal = wide;
      end
      default:   dec.legal = 1'b0;
    endcase
  end

  // R1: a legal 64-bit element decode only comes from the quadword opcode with the prefix
  p_qword_needs_wide_r1: assert property (@(posedge clk) disable iff (rst)
    (dec.legal && dec.sz == EL_64) |-> (opcode == OPC_QWORD && wide));
endmodule

// File: rtl/unpkh_interleave.sv
module unpkh_interleave #(
  parameter int OPW = 128,
  parameter int ELW = 8
) (
  input  logic [OPW/2-1:0] dh,
  input  logic [OPW/2-1:0] sh,
  output logic [OPW-1:0]   r
);
  localparam int HALF = OPW / 2;
  localparam int NEL  = HALF / ELW;

  for (genvar k = 0; k < NEL; k++) begin : g_el
    assign r[(2*k)*ELW   +: ELW] = dh[k*ELW +: ELW];
    assign r[(2*k+1)*ELW +: ELW] = sh[k*ELW +: ELW];
  end
endmodule

// File: rtl/unpkh_stage.sv
module unpkh_stage #(
  parameter int DW = 128,
  parameter int MW = 2
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          in_valid,
  output logic          in_ready,
  input  logic          legal,
  input  logic [DW-1:0] res_in,
  input  logic [MW-1:0] wmask_in,
  output logic          out_valid,
  input  logic          out_ready,
  output logic [DW-1:0] out_result,
  output logic [MW-1:0] out_wmask,
  output logic          out_illegal
);
  logic fire;

  assign in_ready = !out_valid || out_ready;
  assign fire     = in_valid && in_ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      out_valid   <= 1'b0;
      out_illegal <= 1'b0;
      out_result  <= '0;
      out_wmask   <= '0;
    end else begin
      out_illegal <= fire && !legal;
      if (fire) begin
        out_valid <= legal;
        if (legal) begin
          out_result <= res_in;
          out_wmask  <= wmask_in;
        end
      end else if (out_ready) begin
        out_valid <= 1'b0;
      end
    end
  end

  p_hold_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_result) && $stable(out_wmask)));

  p_latency_r8: assert property (@(posedge clk) disable iff (rst)
    (in_valid && in_ready && legal) |=> out_valid);

  p_illegal_no_valid_r7: assert property (@(posedge clk) disable iff (rst)
    out_illegal |-> !out_valid);

  p_reset_clears_r10: assert property (@(posedge clk)
    $past(rst) |-> (!out_valid && !out_illegal));
endmodule

// File: rtl/unpack_hi_unit.sv
module unpack_hi_unit
  import unpkh_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [7:0]        in_opcode,
  input  logic              in_wide,
  input  logic [DATA_W-1:0] in_dst,
  input  logic [DATA_W-1:0] in_src,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_result,
  output logic [N_LANES-1:0] out_wmask,
  output logic              out_illegal
);
  localparam int NAR_W  = DATA_W / 2;
  localparam int WHALF  = DATA_W / 2;
  localparam int NHALF  = NAR_W / 2;

  dec_t              dec;
  logic [DATA_W-1:0] wide_res [N_SIZES];
  logic [NAR_W-1:0]  nar_res  [N_SIZES];
  logic [DATA_W-1:0] sel_res;
  logic [N_LANES-1:0] sel_mask;
  logic              unused_lo;

  assign unused_lo = ^{in_dst[NHALF-1:0], in_src[NHALF-1:0]};

  unpkh_decode u_dec (
    .clk    (clk),
    .rst    (rst),
    .opcode (in_opcode),
    .wide   (in_wide),
    .dec    (dec)
  );

  for (genvar z = 0; z < N_SIZES; z++) begin : g_sz
    localparam int ELW = 8 << z;
    unpkh_interleave #(.OPW(DATA_W), .ELW(ELW)) u_w (
      .dh (in_dst[DATA_W-1:WHALF]),
      .sh (in_src[DATA_W-1:WHALF]),
      .r  (wide_res[z])
    );
    if (ELW <= NHALF) begin : g_nar
      unpkh_interleave #(.OPW(NAR_W), .ELW(ELW)) u_n (
        .dh (in_dst[NAR_W-1:NHALF]),
        .sh (in_src[NAR_W-1:NHALF]),
        .r  (nar_res[z])
      );
    end else begin : g_none
      assign nar_res[z] = '0;
    end
  end

  always_comb begin
    if (dec.wide) begin
      sel_res  = wide_res[dec.sz];
      sel_mask = '1;
    end else begin
      sel_res  = {{(DATA_W-NAR_W){1'b0}}, nar_res[dec.sz]};
      sel_mask = {{(N_LANES-1){1'b0}}, 1'b1};
    end
  end

  unpkh_stage #(.DW(DATA_W), .MW(N_LANES)) u_stage (
    .clk         (clk),
    .rst         (rst),
    .in_valid    (in_valid),
    .in_ready    (in_ready),
    .legal       (dec.legal),
    .res_in      (sel_res),
    .wmask_in    (sel_mask),
    .out_valid   (out_valid),
    .out_ready   (out_ready),
    .out_result  (out_result),
    .out_wmask   (out_wmask),
    .out_illegal (out_illegal)
  );

  // R6: a narrow-form result never carries data in its upper lane
  p_narrow_upper_zero_r6: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_wmask[N_LANES-1]) |-> (out_result[DATA_W-1:NAR_W] == '0));

  // R9: a stalled result blocks new input
  p_stall_blocks_r9: assert property (@(posedge clk) disable iff (rst)
    (out_valid && !out_ready) |-> !in_ready);
endmodule

// File: tb/sim_unpack_hi_unit.sv
module sim_unpack_hi_unit;
  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [7:0]   in_opcode = 8'h00;
  logic         in_wide = 1'b0;
  logic [127:0] in_dst = '0;
  logic [127:0] in_src = '0;
  logic         out_valid;
  logic         out_ready = 1'b1;
  logic [127:0] out_result;
  logic [1:0]   out_wmask;
  logic         out_illegal;

  int n_cmp = 0;
  int n_bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  unpack_hi_unit u0 (
    .clk(clk), .rst(rst), .in_valid(in_valid), .in_ready(in_ready),
    .in_opcode(in_opcode), .in_wide(in_wide), .in_dst(in_dst), .in_src(in_src),
    .out_valid(out_valid), .out_ready(out_ready), .out_result(out_result),
    .out_wmask(out_wmask), .out_illegal(out_illegal)
  );

  function automatic bit ref_legal(input logic [7:0] op, input logic w);
    return (op == 8'h68) || (op == 8'h69) || (op == 8'h6A) || (op == 8'h6D && w);
  endfunction

  function automatic logic [127:0] ref_res(input logic [7:0] op, input logic w,
                                           input logic [127:0] d, input logic [127:0] s);
    logic [127:0] r;
    int e, ow, hw, k, j;
    r = '0;
    e = (op == 8'h68) ? 8 : (op == 8'h69) ? 16 : (op == 8'h6A) ? 32 : 64;
    ow = w ? 128 : 64;
    hw = ow / 2;
    for (int b = 0; b < hw; b++) begin
      k = b / e;
      j = b % e;
      r[2*k*e + j]     = d[hw + b];
      r[(2*k+1)*e + j] = s[hw + b];
    end
    return r;
  endfunction

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    n_cmp++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_op(input string req, input logic [7:0] op, input logic w,
                       input logic [127:0] d, input logic [127:0] s);
    @(negedge clk);
    in_opcode = op; in_wide = w; in_dst = d; in_src = s; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    if (ref_legal(op, w)) begin
      chk({req, " R8 valid"}, {127'd0, out_valid}, 128'd1);
      chk({req, " result"}, out_result, ref_res(op, w, d, s));
      chk({req, " R6 wmask"}, {126'd0, out_wmask}, w ? 128'd3 : 128'd1);
      chk({req, " R7 no illegal"}, {127'd0, out_illegal}, 128'd0);
    end else begin
      chk({req, " R7 illegal"}, {127'd0, out_illegal}, 128'd1);
      chk({req, " R7 no valid"}, {127'd0, out_valid}, 128'd0);
    end
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      n_bad++;
      $display("FAIL watchdog expired actual=running expected=done");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    logic [127:0] d, s, r1;
    logic [7:0] ops [5];
    void'($urandom(32'd1234));
    ops[0] = 8'h68; ops[1] = 8'h69; ops[2] = 8'h6A; ops[3] = 8'h6D; ops[4] = 8'h00;
    repeat (3) @(negedge clk);
    // R10 reset state
    chk("R10 valid after reset", {127'd0, out_valid}, 128'd0);
    chk("R10 illegal after reset", {127'd0, out_illegal}, 128'd0);
    rst = 1'b0;

    // R3 R1 narrow byte, explicit pattern
    d = 128'h0; s = 128'h0;
    d[63:0] = 64'h8877665544332211; s[63:0] = 64'hFFEEDDCCBBAA9988;
    do_op("R3 R1 byte64", 8'h68, 1'b0, d, s);
    chk("R3 byte64 literal", out_result, 128'h0000000000000000_FF88EE77DD66CC55);
    // R2 low half disturbance, narrow
    d[31:0] = 32'hDEADBEEF; s[31:0] = 32'h12345678; d[127:64] = '1;
    do_op("R2 narrow low ignored", 8'h68, 1'b0, d, s);
    chk("R2 narrow same", out_result, 128'h0000000000000000_FF88EE77DD66CC55);
    // R4 quadword
    d = {64'hAAAA_BBBB_CCCC_DDDD, 64'h1111_2222_3333_4444};
    s = {64'h5555_6666_7777_8888, 64'h9999_0000_1212_3434};
    do_op("R4 R1 qword", 8'h6D, 1'b1, d, s);
    chk("R4 qword literal", out_result, {64'h5555_6666_7777_8888, 64'hAAAA_BBBB_CCCC_DDDD});
    // R2 wide low half ignored
    d[63:0] = '0; s[63:0] = '1;
    do_op("R2 wide low ignored", 8'h6D, 1'b1, d, s);
    chk("R2 wide same", out_result, {64'h5555_6666_7777_8888, 64'hAAAA_BBBB_CCCC_DDDD});
    // R5 zero source
    d = 128'h8F7E6D5C4B3A2918_0706050403020100;
    do_op("R5 zero src byte128", 8'h68, 1'b1, d, 128'd0);
    chk("R5 byte zext", out_result, 128'h008F007E006D005C_004B003A00290018);
    do_op("R5 zero src word128", 8'h69, 1'b1, d, 128'd0);
    chk("R5 word zext", out_result, 128'h00008F7E00006D5C_00004B3A00002918);
    do_op("R5 zero src dword64", 8'h6A, 1'b0, d, 128'd0);
    chk("R5 dword zext", out_result, 128'h0000000000000000_0000000007060504);
    // R7 illegal cases
    do_op("R7 qword narrow", 8'h6D, 1'b0, d, s);
    do_op("R7 bad opcode", 8'h60, 1'b1, d, s);

    // R9 stall with waiting operation
    out_ready = 1'b0;
    d = {$urandom, $urandom, $urandom, $urandom};
    s = {$urandom, $urandom, $urandom, $urandom};
    do_op("R9 stall first", 8'h69, 1'b1, d, s);
    r1 = ref_res(8'h69, 1'b1, d, s);
    in_opcode = 8'h6A; in_wide = 1'b1; in_dst = ~d; in_src = ~s; in_valid = 1'b1;
    chk("R9 ready low", {127'd0, in_ready}, 128'd0);
    @(negedge clk);
    chk("R9 held result", out_result, r1);
    chk("R9 held valid", {127'd0, out_valid}, 128'd1);
    out_ready = 1'b1;
    @(negedge clk);
    in_valid = 1'b0;
    chk("R9 R8 second result", out_result, ref_res(8'h6A, 1'b1, ~d, ~s));
    chk("R9 second valid", {127'd0, out_valid}, 128'd1);

    // random mix
    for (int i = 0; i < 400; i++) begin
      logic [7:0] op;
      op = ops[$urandom_range(0, 4)];
      if (op == 8'h00) op = 8'($urandom);
      d = {$urandom, $urandom, $urandom, $urandom};
      s = ($urandom_range(0, 7) == 0) ? 128'd0 : {$urandom, $urandom, $urandom, $urandom};
      do_op("R1 R3 random", op, 1'($urandom), d, s);
    end

    // R10 reset mid-stream
    @(negedge clk);
    in_opcode = 8'h68; in_wide = 1'b1; in_valid = 1'b1;
    @(negedge clk);
    in_valid = 1'b0; rst = 1'b1;
    @(negedge clk);
    chk("R10 valid cleared", {127'd0, out_valid}, 128'd0);
    rst = 1'b0;

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule